// File: doc/BRIEF.md
# Freezing Performance Counter Bank

This block is the counting core of a processor performance-monitoring unit. It holds a parameterised number of event counters, each made of a control register and a 47-bit count register. The control register picks one event line, a mask of the privilege levels that may count, an instruction-address window filter, a sibling-thread scope option and an interrupt enable. The event sources present one line per event for the local hardware thread and one for the sibling thread. They also present the current privilege level and the retiring instruction address. Software programs and reads every register over a single-cycle register bus with combinational read data.

One global enable bit starts and stops every counter in the same cycle. When any counter carries out of bit 46, the block marks that counter in the overflow status register and sets the freeze bit. From the next cycle on, no counter moves until software clears the freeze bit. All counts taken up to the overflow therefore stay consistent with one another. A level interrupt is raised while any flagged counter has its interrupt enable set. A count read returns the 47-bit value sign-extended to 64 bits.

Only the first `NUM_CORE` counters may also add sibling-thread events. The remaining counters always count for the local thread alone.

Top module: `pmu_cnt_bank`

## Requirements
- R1: After reset every count, control, status and window register reads 0, the global enable is off and `irq` is low.
- R2: Word address 0x20+i reads counter i as its 47-bit value sign-extended from bit 46 to 64 bits, and a write there loads bits 46:0 of the write data into counter i in the same clock edge.
- R3: Bit 0 of address 0x01 is the global enable; while it is 0 no counter changes except by a bus write, and setting it lets every counter count from the next cycle.
- R4: Control bits 3:0 (address 0x10+i) select the event line; the counter adds 1 on each clock edge at which the selected local event line is high and counting is allowed.
- R5: Control bits 7:4 are a privilege mask; an event counts only when bit (4 + priv_lvl) of the control register is 1.
- R6: Control bit 8 enables the address window; when set, an event counts only if window low (address 0x02) <= iaddr <= window high (address 0x03), both bounds inclusive.
- R7: Control bit 9 on a counter with index below NUM_CORE also adds the selected sibling event line, giving up to 2 per cycle; on higher-index counters bit 9 has no effect.
- R8: A carry out of bit 46 sets status bit i+1 (address 0x00) and the freeze bit 0 at the same edge, leaves the wrapped low 47 bits in the counter, and stops all counters from the next edge on.
- R9: `irq` is high exactly while some status bit i+1 is set together with control bit 10 of counter i; a wrap on a counter with bit 10 clear still flags and freezes but leaves `irq` low.
- R10: Software writes the status register directly; clearing the freeze bit resumes counting, and a count write while frozen still loads the counter.
- R11: Control reads return bits 10:0 as written with all higher bits 0, and any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW (6) | Register word address |
| bus_wdata | input | DATA_W (64) | Register write data |
| bus_rdata | output | DATA_W (64) | Combinational read data for bus_addr |
| evt_own | input | NUM_EVT (16) | Event lines of the local hardware thread |
| evt_sib | input | NUM_EVT (16) | Event lines of the sibling hardware thread |
| priv_lvl | input | 2 | Current privilege level |
| iaddr | input | IADDR_W (32) | Instruction address tied to the current events |
| irq | output | 1 | Overflow interrupt request, level |

## Verification
Directed patterns come first. A steady single event line, first with the enable off and then on, separates gating from counting. Alternating privilege levels against a sparse mask expose an inverted or shifted mask index. Addresses one below, at, and one above each window bound catch off-by-one comparisons. Local and sibling events together tell a core-scoped low counter from a thread-only high one. Counters are preloaded two or three counts below the carry, which shows that the wrapped value, the flag, the freeze and the interrupt enable all act at the right edge. Constrained random rounds then use random control words, windows, privilege levels and dense event vectors, with counters seeded either near the carry or near zero. These rounds exercise simultaneous wraps, double increments across the carry and status clears in the middle of a run against a cycle model.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   // control word layout; the bit positions are software-visible
   localparam int CTL_W     = 11;
   localparam int SEL_W     = 4;
   localparam int NUM_PRIV  = 4;

   // word addresses of the register file
   localparam int STAT_ADDR = 'h00;
   localparam int GLB_ADDR  = 'h01;
   localparam int WLO_ADDR  = 'h02;
   localparam int WHI_ADDR  = 'h03;
   localparam int CTL_BASE  = 'h10;
   localparam int DAT_BASE  = 'h20;

   typedef struct packed {
      logic                irq_en;      // bit 10
      logic                sib_scope;   // bit 9
      logic                win_en;      // bit 8
      logic [NUM_PRIV-1:0] priv_mask;   // bits 7:4
      logic [SEL_W-1:0]    evt_sel;     // bits 3:0
   } cnt_ctl_t;

endpackage

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
   import pmu_pkg::*;
#(
   parameter int NUM_EVT = 16,
   parameter int IADDR_W = 32,
   parameter bit SIB_OK  = 1'b1
) (
   input  cnt_ctl_t             ctl,
   input  logic [NUM_EVT-1:0]   evt_own,
   input  logic [NUM_EVT-1:0]   evt_sib,
   input  logic [1:0]           priv_lvl,
   input  logic [IADDR_W-1:0]   iaddr,
   input  logic [IADDR_W-1:0]   win_lo,
   input  logic [IADDR_W-1:0]   win_hi,
   output logic [1:0]           inc
);

   logic own_hit;
   logic sib_hit;
   logic sib_use;
   logic priv_ok;
   logic win_ok;
   logic unused_sib;

   always_comb begin
      own_hit = 1'b0;
      sib_hit = 1'b0;
      for (int k = 0; k < NUM_EVT; k++) begin
         if (ctl.evt_sel == SEL_W'(k)) begin
            own_hit = evt_own[k];
            sib_hit = evt_sib[k];
         end
      end
   end

   assign priv_ok = ctl.priv_mask[priv_lvl];
   assign win_ok  = !ctl.win_en || ((iaddr >= win_lo) && (iaddr <= win_hi));

   // counters in the core-capable group may add sibling events
   if (SIB_OK) begin : g_core
      assign sib_use    = ctl.sib_scope & sib_hit;
      assign unused_sib = 1'b0;
   end else begin : g_thread
      assign sib_use    = 1'b0;
      assign unused_sib = ctl.sib_scope ^ sib_hit;
   end

   assign inc = (priv_ok && win_ok) ? ({1'b0, own_hit} + {1'b0, sib_use}) : 2'd0;

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int CNT_W = 47
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [1:0]       inc,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   logic [CNT_W:0] sum;

   assign sum  = {1'b0, cnt} + {{(CNT_W - 1){1'b0}}, inc};
   assign wrap = run && !ld && sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ld) begin
         cnt <= ld_val;
      end else if (run) begin
         cnt <= sum[CNT_W-1:0];
      end
   end

endmodule

// File: rtl/pmu_cnt_bank.sv
module pmu_cnt_bank
   import pmu_pkg::*;
#(
   parameter int NUM_CNT  = 12,
   parameter int NUM_CORE = 4,
   parameter int CNT_W    = 47,
   parameter int DATA_W   = 64,
   parameter int NUM_EVT  = 16,
   parameter int IADDR_W  = 32,
   parameter int BUS_AW   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_EVT-1:0]  evt_own,
   input  logic [NUM_EVT-1:0]  evt_sib,
   input  logic [1:0]          priv_lvl,
   input  logic [IADDR_W-1:0]  iaddr,
   output logic                irq
);

   localparam int EXT_W = DATA_W - CNT_W;

   // elaboration-time parameter checks
   if (NUM_CNT < 1 || NUM_CNT > 16) begin : g_bad_num
      $error("NUM_CNT must lie in 1..16");
   end
   if (NUM_CORE < 0 || NUM_CORE > NUM_CNT) begin : g_bad_core
      $error("NUM_CORE must lie in 0..NUM_CNT");
   end
   if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cw
      $error("CNT_W must be at least 2 and below DATA_W");
   end
   if (NUM_EVT < 1 || NUM_EVT > (1 << SEL_W)) begin : g_bad_evt
      $error("NUM_EVT exceeds the event select field");
   end
   if (IADDR_W > CNT_W || NUM_CNT + 1 > CNT_W || CTL_W > CNT_W) begin : g_bad_fit
      $error("register fields must fit below CNT_W");
   end
   if (BUS_AW < 6) begin : g_bad_aw
      $error("BUS_AW must be at least 6");
   end

   cnt_ctl_t [NUM_CNT-1:0]            ctl_vec;
   logic     [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
   logic     [NUM_CNT-1:0]            wrap;
   logic     [NUM_CNT-1:0]            ie_vec;
   logic     [NUM_CNT-1:0]            ovf_q;
   logic                              frz_q;
   logic                              glb_en_q;
   logic     [IADDR_W-1:0]            win_lo_q;
   logic     [IADDR_W-1:0]            win_hi_q;
   logic                              run;
   logic                              wr_stat;
   logic                              wr_glb;
   logic                              wr_lo;
   logic                              wr_hi;
   logic                              unused_wdata;

   assign run     = glb_en_q && !frz_q;
   assign wr_stat = bus_we && (bus_addr == BUS_AW'(STAT_ADDR));
   assign wr_glb  = bus_we && (bus_addr == BUS_AW'(GLB_ADDR));
   assign wr_lo   = bus_we && (bus_addr == BUS_AW'(WLO_ADDR));
   assign wr_hi   = bus_we && (bus_addr == BUS_AW'(WHI_ADDR));
   assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam logic [BUS_AW-1:0] CTL_A = BUS_AW'(CTL_BASE + i);
      localparam logic [BUS_AW-1:0] DAT_A = BUS_AW'(DAT_BASE + i);

      cnt_ctl_t   ctl_r;
      logic [1:0] inc;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_r <= '0;
         end else if (bus_we && (bus_addr == CTL_A)) begin
            ctl_r <= cnt_ctl_t'(bus_wdata[CTL_W-1:0]);
         end
      end

      assign ctl_vec[i] = ctl_r;
      assign ie_vec[i]  = ctl_r.irq_en;

      pmu_evt_filter #(
         .NUM_EVT (NUM_EVT),
         .IADDR_W (IADDR_W),
         .SIB_OK  (i < NUM_CORE)
      ) u_flt (
         .ctl      (ctl_r),
         .evt_own  (evt_own),
         .evt_sib  (evt_sib),
         .priv_lvl (priv_lvl),
         .iaddr    (iaddr),
         .win_lo   (win_lo_q),
         .win_hi   (win_hi_q),
         .inc      (inc)
      );

      pmu_counter #(
         .CNT_W (CNT_W)
      ) u_ctr (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run),
         .inc    (inc),
         .ld     (bus_we && (bus_addr == DAT_A)),
         .ld_val (bus_wdata[CNT_W-1:0]),
         .cnt    (cnt_q[i]),
         .wrap   (wrap[i])
      );
   end

   // global state: status flags, enable, address window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q    <= '0;
         frz_q    <= 1'b0;
         glb_en_q <= 1'b0;
         win_lo_q <= '0;
         win_hi_q <= '0;
      end else begin
         if (wr_stat) begin
            ovf_q <= bus_wdata[NUM_CNT:1] | wrap;
            frz_q <= bus_wdata[0] | (|wrap);
         end else begin
            ovf_q <= ovf_q | wrap;
            frz_q <= frz_q | (|wrap);
         end
         if (wr_glb) glb_en_q <= bus_wdata[0];
         if (wr_lo)  win_lo_q <= bus_wdata[IADDR_W-1:0];
         if (wr_hi)  win_hi_q <= bus_wdata[IADDR_W-1:0];
      end
   end

   assign irq = |(ovf_q & ie_vec);

   // combinational read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == BUS_AW'(STAT_ADDR)) bus_rdata[NUM_CNT:0] = {ovf_q, frz_q};
      if (bus_addr == BUS_AW'(GLB_ADDR))  bus_rdata[0] = glb_en_q;
      if (bus_addr == BUS_AW'(WLO_ADDR))  bus_rdata[IADDR_W-1:0] = win_lo_q;
      if (bus_addr == BUS_AW'(WHI_ADDR))  bus_rdata[IADDR_W-1:0] = win_hi_q;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (bus_addr == BUS_AW'(CTL_BASE + i)) bus_rdata[CTL_W-1:0] = ctl_vec[i];
         if (bus_addr == BUS_AW'(DAT_BASE + i))
            bus_rdata = {{EXT_W{cnt_q[i][CNT_W-1]}}, cnt_q[i]};
      end
   end

endmodule

// File: rtl/pmu_cnt_bank_chk.sv
module pmu_cnt_bank_chk #(
   parameter int NUM_CNT = 12,
   parameter int CNT_W   = 47
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            bus_we,
   input logic                            glb_en_q,
   input logic                            frz_q,
   input logic [NUM_CNT-1:0]              ovf_q,
   input logic                            irq,
   input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_q
);

   // R8
   frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && !bus_we) |=> $stable(cnt_q));

   // R3
   glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glb_en_q && !bus_we) |=> $stable(cnt_q));

   // R8
   new_ovf_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_we) && ((ovf_q & ~$past(ovf_q)) != '0)) |-> frz_q);

   // R9
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q == '0) |-> !irq);

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_wrap
      // R8
      wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(bus_we) && (cnt_q[i] < $past(cnt_q[i]))) |-> ovf_q[i]);
   end

endmodule

bind pmu_cnt_bank pmu_cnt_bank_chk #(
   .NUM_CNT (NUM_CNT),
   .CNT_W   (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .glb_en_q (glb_en_q),
   .frz_q    (frz_q),
   .ovf_q    (ovf_q),
   .irq      (irq),
   .cnt_q    (cnt_q)
);

// File: tb/sim_pmu_cnt_bank.sv
module sim_pmu_cnt_bank;

   localparam int NC    = 12;
   localparam int NCORE = 4;
   localparam int CW    = 47;
   localparam int DW    = 64;
   localparam int NE    = 16;
   localparam int IAW   = 32;
   localparam int AW    = 6;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_we = 1'b0;
   logic [AW-1:0]  bus_addr = '0;
   logic [DW-1:0]  bus_wdata = '0;
   logic [DW-1:0]  bus_rdata;
   logic [NE-1:0]  evt_own = '0;
   logic [NE-1:0]  evt_sib = '0;
   logic [1:0]     priv_lvl = '0;
   logic [IAW-1:0] iaddr = '0;
   logic           irq;

   always #5 clk = ~clk;

   pmu_cnt_bank #(
      .NUM_CNT(NC), .NUM_CORE(NCORE), .CNT_W(CW), .DATA_W(DW),
      .NUM_EVT(NE), .IADDR_W(IAW), .BUS_AW(AW)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_own(evt_own),
      .evt_sib(evt_sib), .priv_lvl(priv_lvl), .iaddr(iaddr), .irq(irq)
   );

   int errors = 0;
   int checks = 0;

   // reference model state
   logic [CW-1:0]  m_cnt [NC];
   logic [10:0]    m_ctl [NC];
   logic [NC-1:0]  m_ovf;
   logic           m_frz;
   logic           m_en;
   logic [IAW-1:0] m_lo;
   logic [IAW-1:0] m_hi;

   function automatic logic [DW-1:0] sext(logic [CW-1:0] v);
      return {{(DW - CW){v[CW-1]}}, v};
   endfunction

   function automatic int m_inc(int i);
      logic [10:0] c;
      int n;
      c = m_ctl[i];
      n = 0;
      if (!c[4 + int'(priv_lvl)]) return 0;
      if (c[8] && ((iaddr < m_lo) || (iaddr > m_hi))) return 0;
      if (evt_own[c[3:0]]) n++;
      if ((i < NCORE) && c[9] && evt_sib[c[3:0]]) n++;
      return n;
   endfunction

   function automatic logic m_irq();
      logic r;
      r = 1'b0;
      for (int i = 0; i < NC; i++) if (m_ovf[i] && m_ctl[i][10]) r = 1'b1;
      return r;
   endfunction

   task automatic model_step();
      int incs [NC];
      logic [NC-1:0] wr;
      logic [CW:0] s;
      wr = '0;
      for (int i = 0; i < NC; i++) incs[i] = m_inc(i);
      for (int i = 0; i < NC; i++) begin
         if (bus_we && bus_addr == AW'(32 + i)) begin
            m_cnt[i] = bus_wdata[CW-1:0];
         end else if (m_en && !m_frz) begin
            s = {1'b0, m_cnt[i]} + 48'(incs[i]);
            if (s[CW]) wr[i] = 1'b1;
            m_cnt[i] = s[CW-1:0];
         end
      end
      for (int i = 0; i < NC; i++)
         if (bus_we && bus_addr == AW'(16 + i)) m_ctl[i] = bus_wdata[10:0];
      if (bus_we && bus_addr == 6'h00) begin
         m_ovf = bus_wdata[NC:1] | wr;
         m_frz = bus_wdata[0] | (|wr);
      end else begin
         m_ovf = m_ovf | wr;
         m_frz = m_frz | (|wr);
      end
      if (bus_we && bus_addr == 6'h01) m_en = bus_wdata[0];
      if (bus_we && bus_addr == 6'h02) m_lo = bus_wdata[IAW-1:0];
      if (bus_we && bus_addr == 6'h03) m_hi = bus_wdata[IAW-1:0];
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      evt_own = '0; evt_sib = '0;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
      evt_own = '0; evt_sib = '0;
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic run(int n, logic [NE-1:0] own, logic [NE-1:0] sib,
                      logic [1:0] pl, logic [IAW-1:0] ia);
      for (int k = 0; k < n; k++) begin
         evt_own = own; evt_sib = sib; priv_lvl = pl; iaddr = ia;
         tick();
      end
      evt_own = '0; evt_sib = '0;
   endtask

   task automatic check_all(string tag);
      for (int i = 0; i < NC; i++) begin
         rd_chk({tag, " count"}, AW'(32 + i), sext(m_cnt[i]));
         rd_chk({tag, " ctl"}, AW'(16 + i), 64'(m_ctl[i]));
      end
      rd_chk({tag, " status"}, 6'h00, 64'({m_ovf, m_frz}));
      chk({tag, " irq"}, 64'(irq), 64'(m_irq()));
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] snap;
      void'($urandom(32'd1234));
      for (int i = 0; i < NC; i++) begin m_cnt[i] = '0; m_ctl[i] = '0; end
      m_ovf = '0; m_frz = 1'b0; m_en = 1'b0; m_lo = '0; m_hi = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 status", 6'h00, 64'h0);
      rd_chk("R1 enable", 6'h01, 64'h0);
      rd_chk("R1 count0", 6'h20, 64'h0);
      chk("R1 irq", 64'(irq), 64'h0);
      check_all("R1");

      // R11 control readback masking and unmapped address
      wr(6'h10, {DW{1'b1}});
      rd_chk("R11 ctl mask", 6'h10, 64'h7FF);
      rd_chk("R11 unmapped", 6'h3F, 64'h0);
      rd_chk("R11 unmapped low", 6'h08, 64'h0);

      // R2 sign extension and load
      wr(6'h21, 64'h0000_4000_0000_0001);
      rd_chk("R2 negative", 6'h21, 64'hFFFF_C000_0000_0001);
      wr(6'h22, 64'hFFFF_0123_4567_89AB);
      rd_chk("R2 positive", 6'h22, 64'h0000_0123_4567_89AB);
      wr(6'h21, 64'h0); wr(6'h22, 64'h0);

      // R3 / R4: event 3, all privilege levels
      wr(6'h10, 64'h0F3);
      run(5, 16'h0008, 16'h0, 2'd0, 32'h0);
      rd_chk("R3 enable off", 6'h20, 64'h0);
      wr(6'h01, 64'h1);
      run(5, 16'h0008, 16'h0, 2'd0, 32'h0);
      rd_chk("R4 count five", 6'h20, 64'd5);
      run(3, 16'hFFF7, 16'h0, 2'd0, 32'h0);
      rd_chk("R4 other lines", 6'h20, 64'd5);

      // R5 privilege mask 0101
      wr(6'h11, 64'h053);
      run(4, 16'h0008, 16'h0, 2'd1, 32'h0);
      run(3, 16'h0008, 16'h0, 2'd2, 32'h0);
      run(2, 16'h0008, 16'h0, 2'd3, 32'h0);
      rd_chk("R5 masked levels", 6'h21, 64'd3);

      // R6 inclusive address window 0x100..0x1FF
      wr(6'h02, 64'h100); wr(6'h03, 64'h1FF);
      wr(6'h12, 64'h1F3);
      run(1, 16'h0008, 16'h0, 2'd0, 32'h0FF);
      run(1, 16'h0008, 16'h0, 2'd0, 32'h100);
      run(1, 16'h0008, 16'h0, 2'd0, 32'h1FF);
      run(1, 16'h0008, 16'h0, 2'd0, 32'h200);
      rd_chk("R6 window edges", 6'h22, 64'd2);

      // R7 core scope on counter 3, ignored on counter 5
      wr(6'h13, 64'h2F3); wr(6'h15, 64'h2F3);
      run(4, 16'h0008, 16'h0008, 2'd0, 32'h0);
      rd_chk("R7 core scope", 6'h23, 64'd8);
      rd_chk("R7 thread only", 6'h25, 64'd4);
      check_all("R7");

      // R8 / R9: wrap on counter 6 with interrupt enable clear
      wr(6'h16, 64'h0F3);
      wr(6'h26, 64'(CMAX - 47'd2));
      run(3, 16'h0008, 16'h0, 2'd0, 32'h0);
      rd_chk("R8 wrapped value", 6'h26, 64'h0);
      rd_chk("R8 status flag", 6'h00, 64'h81);
      chk("R9 no irq without enable", 64'(irq), 64'h0);
      snap = sext(m_cnt[0]);
      run(3, 16'h0008, 16'h0008, 2'd0, 32'h0);
      rd_chk("R8 frozen count0", 6'h20, snap);
      check_all("R8");

      // R10 load while frozen, then clear freeze
      wr(6'h20, 64'h55);
      rd_chk("R10 load frozen", 6'h20, 64'h55);
      wr(6'h00, 64'h0);
      run(2, 16'h0008, 16'h0, 2'd0, 32'h0);
      rd_chk("R10 resumed", 6'h20, 64'h57);

      // R9 wrap with interrupt enable
      wr(6'h17, 64'h4F3);
      wr(6'h27, 64'(CMAX));
      run(1, 16'h0008, 16'h0, 2'd0, 32'h0);
      rd_chk("R9 status", 6'h00, 64'h101);
      chk("R9 irq raised", 64'(irq), 64'h1);
      wr(6'h00, 64'h0);
      chk("R9 irq cleared", 64'(irq), 64'h0);
      check_all("R9");

      // constrained random rounds against the model
      for (int r = 0; r < 8; r++) begin
         logic [IAW-1:0] lo;
         wr(6'h01, 64'h0);
         for (int i = 0; i < NC; i++) begin
            wr(AW'(16 + i), 64'($urandom & 32'h7FF));
            if ($urandom % 2 == 1) wr(AW'(32 + i), 64'(CMAX - 47'($urandom % 40)));
            else wr(AW'(32 + i), 64'($urandom % 1000));
         end
         lo = $urandom % 512;
         wr(6'h02, 64'(lo));
         wr(6'h03, 64'(lo + ($urandom % 512)));
         wr(6'h00, 64'h0);
         wr(6'h01, 64'h1);
         for (int c = 0; c < 60; c++) begin
            if (c % 20 == 19) wr(6'h00, 64'h0);
            else run(1, NE'($urandom), NE'($urandom), 2'($urandom), $urandom % 1024);
         end
         check_all("R8 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule